// File: doc/BRIEF.md
# STM-1 Section Overhead Monitor

This block watches a byte-wide STM-1 receive stream. It finds the frame from the six-byte framing run, then keeps a row and column position over the 9 x 270 byte frame. It raises an in-frame flag once alignment is confirmed. It drops that flag after repeated framing misses and then searches for the run again.

While the block is aligned, it computes an even bit-interleaved parity (BIP-8) over every byte of each whole frame, exactly as the bytes are received. It compares that value with the regenerator parity byte carried in the next frame and reports, once per frame, how many of the eight bit positions disagree. It also captures four section overhead bytes: the section trace, the two protection-switching bytes and the synchronisation status byte. These are presented together with a one-cycle strobe once per frame.

Bytes arrive on a valid/ready interface. The block never applies back-pressure: `in_ready` is always high, a byte is taken in every cycle where `in_valid` is high, and idle cycles neither advance the frame position nor change any state.

Top module: `stm1_oh_monitor`

## Requirements
- R1: After reset, `in_frame`, `b1_err_valid` and `oh_valid` are low.
- R2: Framing run. The framing run is three bytes 0xF6 followed by three bytes 0x28, which fill row 0, columns 0 to 5 (rows and columns counted from 0). One run seen while searching does not raise `in_frame`. A second run at the expected position one frame later raises it.
- R3: While alignment is pending after the first run, a wrong run at the expected position sends the block back to searching, so one further good run does not raise `in_frame`.
- R4: While aligned, three consecutive framing misses followed by a good run keep `in_frame` high. The fourth consecutive miss drops it.
- R5: The parity for a frame is bitwise even parity: bit k is the XOR of bit k of all 2430 bytes of that frame, counted from row 0 column 0.
- R6: The parity byte at row 1, column 0 is compared with the previous frame's parity. No comparison is reported for the first frame after `in_frame` rises.
- R7: For each aligned frame after the first, `b1_err_valid` pulses for exactly one cycle. `b1_err_bits` then gives the number of differing bit positions, from 0 to 8.
- R8: While aligned, the bytes at row 0 column 6 (trace), row 4 column 3 and row 4 column 6 (protection bytes) and row 8 column 0 (sync status) are captured. They are shown on `oh_j0`, `oh_k1`, `oh_k2` and `oh_s1`, with a single-cycle `oh_valid` pulse once per frame.
- R9: Cycles with `in_valid` low do not advance the frame position, the parity or the alignment state.
- R10: `in_ready` is always high; the block accepts a byte in every valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte present |
| in_ready | output | 1 | Always 1; no back-pressure |
| in_data | input | 8 | Receive byte (scrambled line data) |
| in_frame | output | 1 | Frame alignment confirmed |
| b1_err_valid | output | 1 | One-cycle pulse per compared frame |
| b1_err_bits | output | 4 | Count of mismatching parity bits |
| oh_valid | output | 1 | One-cycle strobe, captured bytes updated |
| oh_j0 | output | 8 | Section trace byte |
| oh_k1 | output | 8 | First protection byte |
| oh_k2 | output | 8 | Second protection byte |
| oh_s1 | output | 8 | Synchronisation status byte |

## Verification
The hardest case to reach from the ports is the edge of the alignment hysteresis. The block must stay aligned through exactly three missed framing runs, lose alignment on the fourth, and withhold the parity report on the first frame after it realigns. The bench reaches this by corrupting the last framing byte in a counted series of otherwise valid frames. It then sends one good, one bad and two good frames, and checks at each frame boundary that no parity pulse appears. The parity comparison itself is swept over error masks of weight 0 to 8, with and without idle gaps in the stream.

// File: rtl/stm1_oh_pkg.sv
package stm1_oh_pkg;

  typedef enum logic [1:0] {
    ALN_SEARCH  = 2'd0,
    ALN_PENDING = 2'd1,
    ALN_LOCKED  = 2'd2
  } align_state_t;

  // overhead positions that neighbours decode (row, column from 0)
  localparam int CHK_ROW = 0;
  localparam int CHK_COL = 5;
  localparam int TRC_ROW = 0;
  localparam int TRC_COL = 6;
  localparam int PAR_ROW = 1;
  localparam int PAR_COL = 0;
  localparam int PS1_ROW = 4;
  localparam int PS1_COL = 3;
  localparam int PS2_ROW = 4;
  localparam int PS2_COL = 6;
  localparam int SYN_ROW = 8;
  localparam int SYN_COL = 0;

  function automatic logic [3:0] bit_diff(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, a[i] ^ b[i]};
    return n;
  endfunction

endpackage

// File: rtl/stm1_frame_align.sv
module stm1_frame_align
  import stm1_oh_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int CONFIRM    = 2,
  parameter int MISS_LIMIT = 4,
  parameter logic [7:0] A1 = 8'hF6,
  parameter logic [7:0] A2 = 8'h28,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic [ROW_W-1:0] cur_row,
  output logic [COL_W-1:0] cur_col,
  output align_state_t     state
);
  localparam int CMAX  = (CONFIRM > MISS_LIMIT) ? CONFIRM : MISS_LIMIT;
  localparam int CNT_W = $clog2(CMAX + 1);

  logic [4:0][7:0]  hist_q;
  logic [ROW_W-1:0] row_q, nxt_row;
  logic [COL_W-1:0] col_q, nxt_col;
  logic [CNT_W-1:0] hits_q, miss_q;
  align_state_t     st_q;
  logic             run_hit, at_check;

  assign run_hit = (hist_q[4] == A1) && (hist_q[3] == A1) && (hist_q[2] == A1) &&
                   (hist_q[1] == A2) && (hist_q[0] == A2) && (in_data == A2);
  assign at_check = (row_q == ROW_W'(CHK_ROW)) && (col_q == COL_W'(CHK_COL));

  always_comb begin
    nxt_row = row_q;
    nxt_col = col_q + COL_W'(1);
    if (col_q == COL_W'(COLS - 1)) begin
      nxt_col = '0;
      nxt_row = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      hits_q <= '0;
      miss_q <= '0;
      st_q   <= ALN_SEARCH;
    end else if (in_valid) begin
      hist_q <= {hist_q[3:0], in_data};
      unique case (st_q)
        ALN_SEARCH: begin
          if (run_hit) begin
            row_q  <= ROW_W'(CHK_ROW);
            col_q  <= COL_W'(CHK_COL + 1);
            hits_q <= CNT_W'(1);
            miss_q <= '0;
            st_q   <= (CONFIRM <= 1) ? ALN_LOCKED : ALN_PENDING;
          end
        end
        ALN_PENDING: begin
          row_q <= nxt_row;
          col_q <= nxt_col;
          if (at_check) begin
            if (!run_hit) begin
              st_q <= ALN_SEARCH;
            end else if (hits_q + CNT_W'(1) >= CNT_W'(CONFIRM)) begin
              st_q   <= ALN_LOCKED;
              miss_q <= '0;
            end else begin
              hits_q <= hits_q + CNT_W'(1);
            end
          end
        end
        default: begin
          row_q <= nxt_row;
          col_q <= nxt_col;
          if (at_check) begin
            if (run_hit) begin
              miss_q <= '0;
            end else if (miss_q + CNT_W'(1) >= CNT_W'(MISS_LIMIT)) begin
              st_q <= ALN_SEARCH;
            end else begin
              miss_q <= miss_q + CNT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign cur_row = row_q;
  assign cur_col = col_q;
  assign state   = st_q;

endmodule

// File: rtl/stm1_bip8_check.sv
module stm1_bip8_check
  import stm1_oh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       locked,
  input  logic       byte_ok,
  input  logic [7:0] in_data,
  input  logic       is_first,
  input  logic       is_last,
  input  logic       is_par,
  output logic       err_valid,
  output logic [3:0] err_bits
);
  logic [7:0] acc_q, ref_q;
  logic       acc_full_q, ref_ok_q;
  logic       ev_q;
  logic [3:0] eb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      ref_q      <= '0;
      acc_full_q <= 1'b0;
      ref_ok_q   <= 1'b0;
      ev_q       <= 1'b0;
      eb_q       <= '0;
    end else begin
      ev_q <= 1'b0;
      if (!active) begin
        acc_full_q <= 1'b0;
        ref_ok_q   <= 1'b0;
      end else if (byte_ok) begin
        if (is_first) begin
          acc_q      <= in_data;
          acc_full_q <= 1'b1;
        end else begin
          acc_q <= acc_q ^ in_data;
        end
        if (is_last) begin
          ref_q    <= acc_q ^ in_data;
          ref_ok_q <= acc_full_q && locked;
        end
        if (is_par && locked && ref_ok_q) begin
          ev_q <= 1'b1;
          eb_q <= bit_diff(ref_q, in_data);
        end
      end
    end
  end

  assign err_valid = ev_q;
  assign err_bits  = eb_q;

endmodule

// File: rtl/stm1_oh_capture.sv
module stm1_oh_capture
  import stm1_oh_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [7:0]       in_data,
  output logic [7:0]       trc,
  output logic [7:0]       ps1,
  output logic [7:0]       ps2,
  output logic [7:0]       syn,
  output logic             strobe
);
  function automatic logic at(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                              input int pr, input int pc);
    return (r == ROW_W'(pr)) && (c == COL_W'(pc));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trc    <= '0;
      ps1    <= '0;
      ps2    <= '0;
      syn    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (take) begin
        if (at(row, col, TRC_ROW, TRC_COL)) trc <= in_data;
        if (at(row, col, PS1_ROW, PS1_COL)) ps1 <= in_data;
        if (at(row, col, PS2_ROW, PS2_COL)) ps2 <= in_data;
        if (at(row, col, SYN_ROW, SYN_COL)) begin
          syn    <= in_data;
          strobe <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stm1_oh_monitor.sv
module stm1_oh_monitor
  import stm1_oh_pkg::*;
#(
  parameter int ROWS       = 9,
  parameter int COLS       = 270,
  parameter int CONFIRM    = 2,
  parameter int MISS_LIMIT = 4,
  parameter logic [7:0] A1 = 8'hF6,
  parameter logic [7:0] A2 = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       in_frame,
  output logic       b1_err_valid,
  output logic [3:0] b1_err_bits,
  output logic       oh_valid,
  output logic [7:0] oh_j0,
  output logic [7:0] oh_k1,
  output logic [7:0] oh_k2,
  output logic [7:0] oh_s1
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  align_state_t     st;
  logic             active, locked, byte_ok;
  logic             is_first, is_last, is_par;

  stm1_frame_align #(
    .ROWS(ROWS), .COLS(COLS), .CONFIRM(CONFIRM), .MISS_LIMIT(MISS_LIMIT),
    .A1(A1), .A2(A2)
  ) align_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cur_row(row), .cur_col(col), .state(st)
  );

  assign active   = (st != ALN_SEARCH);
  assign locked   = (st == ALN_LOCKED);
  assign byte_ok  = in_valid && active;
  assign is_first = (row == '0) && (col == '0);
  assign is_last  = (row == ROW_W'(ROWS - 1)) && (col == COL_W'(COLS - 1));
  assign is_par   = (row == ROW_W'(PAR_ROW)) && (col == COL_W'(PAR_COL));

  stm1_bip8_check par_i (
    .clk(clk), .rst_n(rst_n), .active(active), .locked(locked),
    .byte_ok(byte_ok), .in_data(in_data), .is_first(is_first),
    .is_last(is_last), .is_par(is_par),
    .err_valid(b1_err_valid), .err_bits(b1_err_bits)
  );

  stm1_oh_capture #(.ROW_W(ROW_W), .COL_W(COL_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .take(byte_ok && locked), .row(row), .col(col),
    .in_data(in_data), .trc(oh_j0), .ps1(oh_k1), .ps2(oh_k2), .syn(oh_s1),
    .strobe(oh_valid)
  );

  assign in_ready = 1'b1;
  assign in_frame = locked;

endmodule

// File: rtl/stm1_oh_monitor_checker.sv
module stm1_oh_monitor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_frame,
  input logic       b1_err_valid,
  input logic [3:0] b1_err_bits,
  input logic       oh_valid
);
  assert_err_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err_valid |-> (b1_err_bits <= 4'd8));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err_valid |=> !b1_err_valid);

  assert_err_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b1_err_valid |-> in_frame);

  assert_oh_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oh_valid |=> !oh_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(in_frame));

  assert_gain_on_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_frame) |-> $past(in_valid));
endmodule

bind stm1_oh_monitor stm1_oh_monitor_checker chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
  .b1_err_valid(b1_err_valid), .b1_err_bits(b1_err_bits), .oh_valid(oh_valid)
);

// File: tb/stm1_oh_monitor_tb_top.sv
module stm1_oh_monitor_tb_top;
  localparam int ROWS = 9;
  localparam int COLS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, in_frame, b1_err_valid, oh_valid;
  logic [3:0] b1_err_bits;
  logic [7:0] oh_j0, oh_k1, oh_k2, oh_s1;

  always #2 clk = ~clk;

  stm1_oh_monitor #(.ROWS(ROWS), .COLS(COLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_frame(in_frame), .b1_err_valid(b1_err_valid),
    .b1_err_bits(b1_err_bits), .oh_valid(oh_valid), .oh_j0(oh_j0),
    .oh_k1(oh_k1), .oh_k2(oh_k2), .oh_s1(oh_s1)
  );

  int checks = 0, errors = 0, b1_cnt = 0, b1_last = 0, oh_cnt = 0;
  bit done = 1'b0;
  logic [7:0] prev_bip = '0;

  always @(negedge clk) if (rst_n) begin
    if (b1_err_valid) begin b1_cnt++; b1_last = int'(b1_err_bits); end
    if (oh_valid) oh_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fill(input int fid, input int r, input int c);
    return 8'((fid * 37 + r * 29 + c * 11 + 5) & 255);
  endfunction

  task automatic drive(input logic [7:0] b, input bit gap);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = b;
    if (gap) begin @(posedge clk); #1; in_valid = 1'b0; end
  endtask

  // sends one frame; bip returns the XOR of all its bytes
  task automatic send_frame(input int fid, input logic [7:0] par, input bit bad,
                            input bit gaps, output logic [7:0] bip);
    logic [7:0] b;
    bip = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        b = fill(fid, r, c);
        if (r == 0 && c < 3) b = 8'hF6;
        else if (r == 0 && c < 5) b = 8'h28;
        else if (r == 0 && c == 5) b = bad ? 8'h00 : 8'h28;
        else if (r == 0 && c == 6) b = 8'(8'h10 + fid);
        else if (r == 1 && c == 0) b = par;
        else if (r == 4 && c == 3) b = 8'(8'h60 + fid);
        else if (r == 4 && c == 6) b = 8'(8'h90 + fid);
        else if (r == 8 && c == 0) b = 8'(8'hC0 + fid);
        bip ^= b;
        drive(b, gaps && ((r * COLS + c) % 5 == 2));
      end
    end
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_oh(input int fid, input string req);
    check(oh_j0 == 8'(8'h10 + fid), req, int'(oh_j0), 8'h10 + fid);
    check(oh_k1 == 8'(8'h60 + fid), req, int'(oh_k1), 8'h60 + fid);
    check(oh_k2 == 8'(8'h90 + fid), req, int'(oh_k2), 8'h90 + fid);
    check(oh_s1 == 8'(8'hC0 + fid), req, int'(oh_s1), 8'hC0 + fid);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] bip;
    logic [7:0] mask;
    int c0, o0, fid;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 / R10: reset state
    check(in_frame == 1'b0, "R1 in_frame", int'(in_frame), 0);
    check(b1_err_valid == 1'b0 && oh_valid == 1'b0, "R1 pulses", int'(b1_err_valid), 0);
    check(in_ready == 1'b1, "R10 ready in reset", int'(in_ready), 1);
    @(posedge clk); #1; rst_n = 1'b1;

    // R2: one run is not enough, two are
    send_frame(0, 8'h00, 1'b0, 1'b0, bip);
    check(in_frame == 1'b0, "R2 one run", int'(in_frame), 0);
    send_frame(1, 8'h5A, 1'b0, 1'b0, bip);
    prev_bip = bip;
    check(in_frame == 1'b1, "R2 second run", int'(in_frame), 1);
    check(b1_cnt == 0, "R6 no compare first frame", b1_cnt, 0);
    check(oh_cnt == 1, "R8 strobe count", oh_cnt, 1);
    check_oh(1, "R8 captured bytes");
    check(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);

    // R5 / R7 / R9: parity error sweep, weights 0..8 and a sparse mask
    fid = 2;
    for (int k = 0; k <= 9; k++) begin
      mask = (k == 9) ? 8'hA5 : 8'((1 << k) - 1);
      c0 = b1_cnt; o0 = oh_cnt;
      send_frame(fid, prev_bip ^ mask, 1'b0, k[0], bip);
      prev_bip = bip;
      check(b1_cnt == c0 + 1, k[0] ? "R9 pulse count with gaps" : "R7 pulse count",
            b1_cnt, c0 + 1);
      check(b1_last == $countones(mask), (k == 0) ? "R5 clean parity" : "R7 bit count",
            b1_last, $countones(mask));
      check(oh_cnt == o0 + 1, "R8 one strobe per frame", oh_cnt, o0 + 1);
      if (k == 3) check_oh(fid, "R9 capture with gaps");
      fid++;
    end

    // R4: three misses then a hit stay aligned
    for (int m = 0; m < 3; m++) begin
      send_frame(fid, prev_bip, 1'b1, 1'b0, bip);
      prev_bip = bip; fid = (fid + 1) % 16;
      check(in_frame == 1'b1, "R4 tolerate miss", int'(in_frame), 1);
    end
    c0 = b1_cnt;
    send_frame(fid, prev_bip, 1'b0, 1'b0, bip);
    prev_bip = bip; fid = (fid + 1) % 16;
    check(in_frame == 1'b1, "R4 hit after three misses", int'(in_frame), 1);
    check(b1_cnt == c0 + 1 && b1_last == 0, "R5 parity after misses", b1_last, 0);

    // R4: fourth consecutive miss drops alignment
    for (int m = 0; m < 4; m++) begin
      send_frame(fid, prev_bip, 1'b1, 1'b0, bip);
      prev_bip = bip; fid = (fid + 1) % 16;
      if (m == 2) check(in_frame == 1'b1, "R4 third miss", int'(in_frame), 1);
    end
    check(in_frame == 1'b0, "R4 fourth miss", int'(in_frame), 0);

    // R3: pending alignment broken by a bad run
    send_frame(fid, 8'h00, 1'b0, 1'b0, bip); fid = (fid + 1) % 16;
    check(in_frame == 1'b0, "R2 single run after loss", int'(in_frame), 0);
    send_frame(fid, 8'h00, 1'b1, 1'b0, bip); fid = (fid + 1) % 16;
    check(in_frame == 1'b0, "R3 bad run while pending", int'(in_frame), 0);
    send_frame(fid, 8'h00, 1'b0, 1'b0, bip); fid = (fid + 1) % 16;
    check(in_frame == 1'b0, "R3 restart search", int'(in_frame), 0);

    // R6: regain, first frame not compared, next one is
    c0 = b1_cnt;
    send_frame(fid, 8'hFF, 1'b0, 1'b0, bip);
    prev_bip = bip; fid = (fid + 1) % 16;
    check(in_frame == 1'b1, "R2 regain", int'(in_frame), 1);
    check(b1_cnt == c0, "R6 no compare after regain", b1_cnt, c0);
    send_frame(fid, prev_bip ^ 8'h0F, 1'b0, 1'b0, bip);
    check(b1_cnt == c0 + 1, "R6 compare resumes", b1_cnt, c0 + 1);
    check(b1_last == 4, "R7 four bits", b1_last, 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule